// File: doc/BRIEF.md
# Indexed Colour Palette with Sequenced Component Access

The block holds a colour lookup table of 260 entries, each entry made of separate 8-bit red, green and blue values. Entries 0 to 255 form the main table that the display pipeline indexes with pixel values. Entries 256 to 259 are four overlay colours used for cursor drawing. Software reaches the table through a 32-bit register port with four word offsets. One register holds an entry pointer. The data offsets move through the red, green and blue components of the pointed entry, one component per access. After the third component the pointer moves on to the next entry, so a whole palette loads as a flat stream of bytes.

A separate display port takes an entry number and returns the packed 24-bit colour one clock later. It never stalls and never interferes with register traffic.

Top module: `palette_lut`

## Requirements
- R1: A full-word write at byte offset 0 loads the entry pointer from data bits 31:24 and sets the component phase to red, even in the middle of a component sequence.
- R2: A full-word write at offset 4 stores data bits 31:24 into the current component of main entry `pointer`. Bits 23:0 are ignored. The phase steps red, then green, then blue.
- R3: After the blue component has been accessed at a data offset, the pointer increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R4: A full-word write at offset 12 stores into overlay entry 256 + (pointer & 3) and uses the same phase sequence and pointer increment as offset 4.
- R5: A full-word read at offset 4 or 12 returns the current component of main entry `pointer` in bits 31:24 with bits 23:0 zero. It advances the phase and pointer exactly as a write does.
- R6: After reset, every component of every entry is zero except entries 255, 256 and 258, which read (255,255,255). The pointer and phase are zero (red).
- R7: The display port returns {red[23:16], green[15:8], blue[7:0]} of entry `pixIndex` one clock after the index is presented. An index above 259 returns zero.
- R8: When a register write and a display lookup hit the same entry in one cycle, the lookup returns the old colour. A lookup in the following cycle returns the new colour.
- R9: An access whose byte enables are not all ones has no effect: nothing is stored, the pointer and phase do not move, and read data is zero.
- R10: Accesses at any offset other than 0, 4 and 12 (including the control word at 8) store nothing and leave the pointer and phase unchanged. Reads at offsets other than 4 and 12 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access present this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 4 | Byte offset of the access |
| regByteEn | input | 4 | Byte enables; only 4'hF is accepted |
| regWdata | input | 32 | Write data; component taken from bits 31:24 |
| regRdata | output | 32 | Read data, valid in the cycle of a read access |
| pixIndex | input | 9 | Display lookup entry number |
| pixColor | output | 24 | Colour of the looked-up entry, one cycle later |

## Verification
The assertions assume that a register access lasts exactly one cycle with its control inputs stable, and that a read consumes its data in that same cycle. The stimulus drives every access just after a rising edge and holds it for one full cycle. It keeps `regValid` low between tasks, so each accepted access advances the sequencer exactly once. The display index is always driven, but a lookup is checked only in cycles the driver has marked. This lets out-of-range indices be used freely.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;
  localparam int MAIN_ENTRIES = 256;
  localparam int OVL_ENTRIES  = 4;
  localparam int TOTAL        = MAIN_ENTRIES + OVL_ENTRIES;
  localparam int ENTRY_W      = $clog2(TOTAL);
  localparam int IDX_W        = $clog2(MAIN_ENTRIES);
  localparam int OVL_W        = $clog2(OVL_ENTRIES);
  localparam int COMP_W       = 8;
  localparam int DATA_W       = 32;

  localparam logic [3:0] OFS_POINTER = 4'd0;
  localparam logic [3:0] OFS_MAIN    = 4'd4;
  localparam logic [3:0] OFS_OVL     = 4'd12;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GREEN = 2'd1, PH_BLUE = 2'd2} phase_e;

  typedef struct packed {
    logic               wrEn;
    logic               rdEn;
    logic [ENTRY_W-1:0] entry;
    phase_e             comp;
  } strobe_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [3:0]        regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [COMP_W-1:0] wrByte,
  output strobe_t           strb
);
  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic             accepted, idxWr, dataAcc, ovlSel;

  assign accepted = regValid && (regByteEn == 4'hF);
  assign idxWr    = accepted && regWrite && (regAddr == OFS_POINTER);
  assign dataAcc  = accepted && ((regAddr == OFS_MAIN) || (regAddr == OFS_OVL));
  assign ovlSel   = regWrite && (regAddr == OFS_OVL);

  always_comb begin
    strb.wrEn  = dataAcc && regWrite;
    strb.rdEn  = dataAcc && !regWrite;
    strb.comp  = phase;
    strb.entry = ovlSel ? (ENTRY_W'(MAIN_ENTRIES) + ENTRY_W'(idx[OVL_W-1:0]))
                        : ENTRY_W'(idx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (idxWr) begin
      idx   <= wrByte[IDX_W-1:0];
      phase <= PH_RED;
    end else if (dataAcc) begin
      case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (idx == $past(wrByte[IDX_W-1:0])) && (phase == PH_RED));
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && phase == PH_RED) |=> (phase == PH_GREEN) && $stable(idx));
  // R3
  blue_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && phase == PH_BLUE) |=> (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(idxWr || dataAcc) |=> $stable(idx) && $stable(phase));
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_lut_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [COMP_W-1:0]   wrByte,
  input  logic [ENTRY_W-1:0]  pixIndex,
  output logic [DATA_W-1:0]   regRdata,
  output logic [3*COMP_W-1:0] pixColor
);
  logic [COMP_W-1:0] redT [TOTAL];
  logic [COMP_W-1:0] grnT [TOTAL];
  logic [COMP_W-1:0] bluT [TOTAL];
  logic [COMP_W-1:0] rdByte;

  function automatic logic [COMP_W-1:0] resetVal(int e);
    return ((e == MAIN_ENTRIES - 1) || (e == MAIN_ENTRIES) || (e == MAIN_ENTRIES + 2))
           ? {COMP_W{1'b1}} : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < TOTAL; e++) begin
        redT[e] <= resetVal(e);
        grnT[e] <= resetVal(e);
        bluT[e] <= resetVal(e);
      end
    end else if (strb.wrEn && (strb.entry < ENTRY_W'(TOTAL))) begin
      case (strb.comp)
        PH_RED:   redT[strb.entry] <= wrByte;
        PH_GREEN: grnT[strb.entry] <= wrByte;
        default:  bluT[strb.entry] <= wrByte;
      endcase
    end
  end

  always_comb begin
    rdByte = '0;
    if (strb.rdEn && (strb.entry < ENTRY_W'(TOTAL))) begin
      case (strb.comp)
        PH_RED:   rdByte = redT[strb.entry];
        PH_GREEN: rdByte = grnT[strb.entry];
        default:  rdByte = bluT[strb.entry];
      endcase
    end
    regRdata = {rdByte, {(DATA_W-COMP_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixColor <= '0;
    else if (pixIndex < ENTRY_W'(TOTAL))
      pixColor <= {redT[pixIndex], grnT[pixIndex], bluT[pixIndex]};
    else pixColor <= '0;
  end

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixIndex >= ENTRY_W'(TOTAL)) |=> (pixColor == '0));
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.comp == PH_RED && strb.entry < ENTRY_W'(TOTAL))
      |=> (redT[$past(strb.entry)] == $past(wrByte)));
  // R5
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |-> (regRdata == '0));
  // R8
  collide_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.comp == PH_BLUE && pixIndex == strb.entry && pixIndex < ENTRY_W'(TOTAL))
      |=> (pixColor[COMP_W-1:0] == $past(bluT[pixIndex])));
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_lut_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regValid,
  input  logic                regWrite,
  input  logic [3:0]          regAddr,
  input  logic [3:0]          regByteEn,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [ENTRY_W-1:0]  pixIndex,
  output logic [3*COMP_W-1:0] pixColor
);
  strobe_t           strb;
  logic [COMP_W-1:0] wrByte;
  logic              unusedBits;

  assign wrByte     = regWdata[DATA_W-1 -: COMP_W];
  assign unusedBits = ^regWdata[DATA_W-COMP_W-1:0];

  palette_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regByteEn(regByteEn), .wrByte(wrByte), .strb(strb)
  );

  palette_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte),
    .pixIndex(pixIndex), .regRdata(regRdata), .pixColor(pixColor)
  );
endmodule

// File: tb/palette_lut_tb.sv
`timescale 1ns/1ps
module palette_lut_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [3:0]  regAddr = '0, regByteEn = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [8:0]  pixIndex = '0;
  logic [23:0] pixColor;

  always #2.5 clk = ~clk;

  palette_lut u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWdata(regWdata),
    .regRdata(regRdata), .pixIndex(pixIndex), .pixColor(pixColor)
  );

  typedef struct { logic [31:0] val; string req; } item_t;
  item_t rdQ[$];
  item_t pixQ[$];

  int checks = 0, errors = 0;
  bit pixReqNow = 0, pixPend = 0, done = 0;

  logic [7:0] mr [260], mg [260], mb [260];
  logic [7:0] mIdx;
  int         mPh;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int e = 0; e < 260; e++) begin
      mr[e] = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      mg[e] = mr[e];
      mb[e] = mr[e];
    end
    mIdx = 0;
    mPh  = 0;
  endtask

  function automatic logic [23:0] modelColor(int e);
    if (e > 259) return 24'h0;
    return {mr[e], mg[e], mb[e]};
  endfunction

  // Driver: one access plus an optional lookup in one cycle; expectations are queued
  task automatic access(bit wr, logic [3:0] addr, logic [3:0] be, logic [31:0] data,
                        int look, string req);
    item_t it;
    int e;
    logic [7:0] c;
    @(posedge clk); #1;
    regValid = 1'b1; regWrite = wr; regAddr = addr; regByteEn = be; regWdata = data;
    if (look >= 0) begin
      pixIndex = 9'(look);
      it.val = {8'h0, modelColor(look)}; it.req = req;
      pixQ.push_back(it);
      pixReqNow = 1;
    end
    it.val = 32'h0; it.req = req;
    if (be == 4'hF) begin
      if (wr && addr == 4'd0) begin
        mIdx = data[31:24]; mPh = 0;
      end else if (addr == 4'd4 || addr == 4'd12) begin
        if (!wr) begin
          c = (mPh == 0) ? mr[mIdx] : (mPh == 1) ? mg[mIdx] : mb[mIdx];
          it.val = {c, 24'h0};
        end else begin
          e = (addr == 4'd12) ? 256 + int'(mIdx[1:0]) : int'(mIdx);
          if (mPh == 0) mr[e] = data[31:24];
          else if (mPh == 1) mg[e] = data[31:24];
          else mb[e] = data[31:24];
        end
        if (mPh == 2) begin mPh = 0; mIdx = mIdx + 8'd1; end
        else mPh++;
      end
    end
    if (!wr) rdQ.push_back(it);
  endtask

  task automatic look(int e, string req);
    @(posedge clk); #1;
    regValid = 1'b0;
    pixIndex = 9'(e);
    pixQ.push_back('{ {8'h0, modelColor(e)}, req });
    pixReqNow = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      regValid = 1'b0;
    end
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    item_t it;
    if (rstN) begin
      if (pixPend) begin
        it = pixQ.pop_front();
        chk(pixColor == it.val[23:0], it.req, {8'h0, pixColor}, it.val);
      end
      pixPend = pixReqNow;
      pixReqNow = 0;
      if (regValid && !regWrite) begin
        it = rdQ.pop_front();
        chk(regRdata == it.val, it.req, regRdata, it.val);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R6 reset contents through the display port
    look(0, "R6"); look(255, "R6"); look(256, "R6");
    look(257, "R6"); look(258, "R6"); look(259, "R6");
    // R6 R5 pointer starts at entry 0, red
    access(0, 4'd4, 4'hF, 0, -1, "R5");
    access(0, 4'd4, 4'hF, 0, -1, "R5");
    access(0, 4'd4, 4'hF, 0, -1, "R5");
    // R2 stream one entry, low bits are junk
    access(1, 4'd0, 4'hF, 32'h0A00_1234, -1, "R1");
    access(1, 4'd4, 4'hF, 32'h11AB_CDEF, -1, "R2");
    access(1, 4'd4, 4'hF, 32'h22FF_FFFF, -1, "R2");
    access(1, 4'd4, 4'hF, 32'h3300_0001, -1, "R2");
    look(10, "R2");
    // R3 increment: the next red lands in entry 11
    access(1, 4'd4, 4'hF, 32'h7700_0000, -1, "R3");
    look(11, "R3");
    // R5 read back entry 10 at both data offsets
    access(1, 4'd0, 4'hF, 32'h0A00_0000, -1, "R1");
    access(0, 4'd4, 4'hF, 0, -1, "R5");
    access(0, 4'd12, 4'hF, 0, -1, "R5");
    access(0, 4'd4, 4'hF, 0, -1, "R5");
    access(0, 4'd4, 4'hF, 0, -1, "R3");
    // R3 wrap from 255 to 0
    access(1, 4'd0, 4'hF, 32'hFF00_0000, -1, "R1");
    access(1, 4'd4, 4'hF, 32'h0100_0000, -1, "R3");
    access(1, 4'd4, 4'hF, 32'h0200_0000, -1, "R3");
    access(1, 4'd4, 4'hF, 32'h0300_0000, -1, "R3");
    access(1, 4'd4, 4'hF, 32'h4400_0000, -1, "R3");
    look(255, "R3"); look(0, "R3");
    // R4 overlay: pointer 6 selects entry 258, then pointer 7 selects 259
    access(1, 4'd0, 4'hF, 32'h0600_0000, -1, "R4");
    access(1, 4'd12, 4'hF, 32'h1200_0000, -1, "R4");
    access(1, 4'd12, 4'hF, 32'h3400_0000, -1, "R4");
    access(1, 4'd12, 4'hF, 32'h5600_0000, -1, "R4");
    access(1, 4'd12, 4'hF, 32'h9900_0000, -1, "R4");
    look(258, "R4"); look(259, "R4"); look(6, "R4");
    // R9 partial accesses ignored
    access(1, 4'd0, 4'hF, 32'h1400_0000, -1, "R9");
    access(1, 4'd4, 4'h7, 32'h9900_0000, -1, "R9");
    access(1, 4'd0, 4'hE, 32'h5000_0000, -1, "R9");
    access(0, 4'd4, 4'h8, 0, -1, "R9");
    access(1, 4'd4, 4'hF, 32'h5500_0000, -1, "R9");
    look(20, "R9");
    // R10 control word and odd offsets ignored
    access(1, 4'd8, 4'hF, 32'hAA00_0000, -1, "R10");
    access(1, 4'd2, 4'hF, 32'hBB00_0000, -1, "R10");
    access(0, 4'd0, 4'hF, 0, -1, "R10");
    access(0, 4'd8, 4'hF, 0, -1, "R10");
    access(1, 4'd4, 4'hF, 32'h6600_0000, -1, "R10");
    look(20, "R10");
    // R1 pointer write mid-sequence resets phase to red
    access(1, 4'd0, 4'hF, 32'h1E00_0000, -1, "R1");
    access(1, 4'd4, 4'hF, 32'h0100_0000, -1, "R1");
    access(1, 4'd0, 4'hF, 32'h1E00_0000, -1, "R1");
    access(1, 4'd4, 4'hF, 32'h0200_0000, -1, "R1");
    look(30, "R1");
    // R8 collision: same-cycle lookup sees old colour, next cycle new
    access(1, 4'd0, 4'hF, 32'h2800_0000, -1, "R8");
    access(1, 4'd4, 4'hF, 32'hA100_0000, 40, "R8");
    look(40, "R8");
    access(1, 4'd4, 4'hF, 32'hB200_0000, 40, "R8");
    access(1, 4'd4, 4'hF, 32'hC300_0000, 40, "R8");
    look(40, "R8");
    // R7 out-of-range lookups
    look(260, "R7"); look(300, "R7"); look(511, "R7"); look(259, "R7");
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule